// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Macrocell

This block models a single programmable-logic macrocell. Its behaviour is set entirely by a static configuration word. An array of programmable AND terms, each built from true or complemented copies of the array inputs, feeds a fixed OR gate. A polarity stage can invert the sum. A storage element can act as a D or a T flip-flop on either clock edge. Multiplexers choose the clock source, the output source and the value returned to the array.

The array inputs are the global input bus plus one feedback line. Two extra product terms have fixed jobs. The first is the control term. In synchronous mode it drives the output enable. In asynchronous mode it becomes the register clock, and the output is then always enabled. The second extra term clears the register at once, whatever the clock is doing.

Configuration is meant to stay constant while the cell runs. It is changed only while `rst_ni` is held low.

Top module: `pterm_macrocell`

## Requirements
- R1: Each array input has a 2-bit literal code: 00 leaves it out, 01 uses it true, 10 uses it complemented, and 11 is reserved and also leaves it out. A product term is the AND of its used literals. A term with no used literal evaluates to 0. The code for term k and input j sits at `cfg_i[6 + 2*(k*9 + j) +: 2]`. Inputs 0 to 7 are `glb_i[j]` and input 8 is the feedback line. Terms 0 to 7 are summed, term 8 is the control term and term 9 is the clear term.
- R2: The cell function f is the OR of terms 0 to 7. It is complemented when `cfg_i[0]` is 1.
- R3: With `cfg_i[4]`=0, `pad_o` follows f combinationally. With `cfg_i[4]`=1, `pad_o` shows the register.
- R4: With `cfg_i[1]`=0, the register loads f on each active clock edge.
- R5: With `cfg_i[1]`=1, the register inverts itself on an active edge when f is 1 and holds its value when f is 0.
- R6: With `cfg_i[2]`=0 the register acts on the rising edge of its selected clock. With `cfg_i[2]`=1 it acts on the falling edge.
- R7: With `cfg_i[3]`=0, the register is clocked by `clk_i` and `pad_oe_o` equals the control term.
- R8: With `cfg_i[3]`=1, the control term is the register clock and `pad_oe_o` is 1.
- R9: While the clear term is 1, the register is 0 at once, with no clock edge needed. The clear overrides any active edge.
- R10: With `cfg_i[5]`=0 the feedback line carries the register. With `cfg_i[5]`=1 it carries `pad_i`. `fb_o` shows the feedback line.
- R11: While `rst_ni` is 0 the register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Global clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| glb_i | input | N_GLB | Global array inputs |
| pad_i | input | 1 | Value read back from the pin |
| cfg_i | input | 6+(N_SUM+2)*2*(N_GLB+1) | Static configuration: mode bits [5:0], then the literal codes |
| pad_o | output | 1 | Pin data, either combinational or registered |
| pad_oe_o | output | 1 | Pin drive enable |
| fb_o | output | 1 | Selected feedback value returned to the array |

## Verification
The assertions check several things on every cycle of `clk_i`:
- that an array with no used literal produces an all-zero term vector;
- that the register is zero under reset and under an active clear;
- that in synchronous mode the D load works on either edge and the T toggle works on the rising edge.

Other behaviours can only be shown by the bench's scenarios. These are the clear taking effect between edges, captures driven by a local clock made from the array, the pin feedback path, the reserved literal code, and the output-enable selection. The bench covers them with directed cases and with random configurations checked against its reference functions.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [1:0] {
    LIT_OFF  = 2'b00,
    LIT_TRUE = 2'b01,
    LIT_COMP = 2'b10,
    LIT_RSVD = 2'b11
  } lit_e;

  // packed from msb: bit5 fb_pin ... bit0 invert
  typedef struct packed {
    logic fb_pin;
    logic out_reg;
    logic async_clk;
    logic neg_edge;
    logic t_mode;
    logic invert;
  } mode_t;

  localparam int unsigned MODE_W = $bits(mode_t);
endpackage

// File: rtl/mc_pterm.sv
module mc_pterm import mc_pkg::*; #(
  parameter int unsigned W = 9
)(
  input  logic [W-1:0]   lit_i,
  input  logic [2*W-1:0] code_i,
  output logic           term_o
);
  logic [W-1:0] used;
  logic [W-1:0] pass;

  for (genvar j = 0; j < W; j++) begin : g_lit
    lit_e sel;
    assign sel     = lit_e'(code_i[2*j +: 2]);
    assign used[j] = (sel == LIT_TRUE) || (sel == LIT_COMP);
    always_comb begin
      unique case (sel)
        LIT_TRUE: pass[j] = lit_i[j];
        LIT_COMP: pass[j] = ~lit_i[j];
        default:  pass[j] = 1'b1;
      endcase
    end
  end

  // empty term reads 0 so it cannot pollute the OR (R1)
  assign term_o = (|used) & (&pass);
endmodule

// File: rtl/mc_array.sv
module mc_array #(
  parameter int unsigned N_IN  = 9,
  parameter int unsigned N_SUM = 8
)(
  input  logic [N_IN-1:0]              lit_i,
  input  logic [(N_SUM+2)*2*N_IN-1:0]  code_i,
  output logic [N_SUM-1:0]             sum_terms_o,
  output logic                         ctl_term_o,
  output logic                         clr_term_o
);
  localparam int unsigned N_TERM = N_SUM + 2;
  localparam int unsigned TW     = 2 * N_IN;

  logic [N_TERM-1:0] terms;

  for (genvar k = 0; k < N_TERM; k++) begin : g_term
    mc_pterm #(.W(N_IN)) u_pt (
      .lit_i  (lit_i),
      .code_i (code_i[k*TW +: TW]),
      .term_o (terms[k])
    );
  end

  assign sum_terms_o = terms[N_SUM-1:0];
  assign ctl_term_o  = terms[N_SUM];
  assign clr_term_o  = terms[N_SUM+1];
endmodule

// File: rtl/mc_store.sv
module mc_store (
  input  logic clk_i,
  input  logic lclk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic async_i,
  input  logic neg_edge_i,
  input  logic t_mode_i,
  input  logic f_i,
  output logic q_o
);
  logic clk_src, clk_eff, clr_n, nxt;

  assign clk_src = async_i ? lclk_i : clk_i;
  assign clk_eff = clk_src ^ neg_edge_i;       // inverted clock gives falling-edge capture
  assign clr_n   = rst_ni & ~clr_i;
  assign nxt     = t_mode_i ? (q_o ^ f_i) : f_i;

  always_ff @(posedge clk_eff or negedge clr_n) begin
    if (!clr_n) q_o <= 1'b0;
    else        q_o <= nxt;
  end
endmodule

// File: rtl/pterm_macrocell.sv
module pterm_macrocell import mc_pkg::*; #(
  parameter int unsigned N_GLB = 8,
  parameter int unsigned N_SUM = 8
)(
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic [N_GLB-1:0]                       glb_i,
  input  logic                                   pad_i,
  input  logic [MODE_W+(N_SUM+2)*2*(N_GLB+1)-1:0] cfg_i,
  output logic                                   pad_o,
  output logic                                   pad_oe_o,
  output logic                                   fb_o
);
  localparam int unsigned ARR_W  = N_GLB + 1;
  localparam int unsigned N_TERM = N_SUM + 2;
  localparam int unsigned CODE_W = N_TERM * 2 * ARR_W;

  mode_t              mode;
  logic [CODE_W-1:0]  code;
  logic [ARR_W-1:0]   arr;
  logic [N_SUM-1:0]   pt_sum;
  logic               pt_ctl, pt_clr;
  logic               fb_val, f_val, q;

  assign mode = mode_t'(cfg_i[MODE_W-1:0]);
  assign code = cfg_i[MODE_W +: CODE_W];

  assign fb_val = mode.fb_pin ? pad_i : q;
  assign arr    = {fb_val, glb_i};

  mc_array #(.N_IN(ARR_W), .N_SUM(N_SUM)) u_array (
    .lit_i       (arr),
    .code_i      (code),
    .sum_terms_o (pt_sum),
    .ctl_term_o  (pt_ctl),
    .clr_term_o  (pt_clr)
  );

  assign f_val = (|pt_sum) ^ mode.invert;

  mc_store u_store (
    .clk_i      (clk_i),
    .lclk_i     (pt_ctl),
    .rst_ni     (rst_ni),
    .clr_i      (pt_clr),
    .async_i    (mode.async_clk),
    .neg_edge_i (mode.neg_edge),
    .t_mode_i   (mode.t_mode),
    .f_i        (f_val),
    .q_o        (q)
  );

  assign pad_o    = mode.out_reg ? q : f_val;
  assign pad_oe_o = mode.async_clk | pt_ctl;   // control term spent on clock in async mode
  assign fb_o     = fb_val;
endmodule

// File: rtl/mc_checker.sv
module mc_checker #(
  parameter int unsigned N_GLB = 8,
  parameter int unsigned N_SUM = 8
)(
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          async_i,
  input logic                          neg_edge_i,
  input logic                          t_mode_i,
  input logic [N_SUM*2*(N_GLB+1)-1:0]  sum_code_i,
  input logic [N_SUM-1:0]              pt_sum_i,
  input logic                          clr_i,
  input logic                          f_i,
  input logic                          q_i
);
  localparam int unsigned N_LIT = N_SUM * (N_GLB + 1);

  logic any_lit;
  always_comb begin
    any_lit = 1'b0;
    for (int i = 0; i < N_LIT; i++)
      if (sum_code_i[2*i +: 2] == 2'b01 || sum_code_i[2*i +: 2] == 2'b10) any_lit = 1'b1;
  end

  p_idle_terms_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_lit |-> pt_sum_i == '0);

  p_reset_zero_r11: assert property (@(posedge clk_i)
    !rst_ni |-> !q_i);

  p_clear_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> !q_i);

  p_d_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!async_i && !neg_edge_i && !t_mode_i && !clr_i) |=> (clr_i || q_i == $past(f_i)));

  p_d_fall_r6: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (!async_i && neg_edge_i && !t_mode_i && !clr_i) |=> (clr_i || q_i == $past(f_i)));

  p_t_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!async_i && !neg_edge_i && t_mode_i && !clr_i) |=> (clr_i || q_i == ($past(q_i) ^ $past(f_i))));
endmodule

bind pterm_macrocell mc_checker #(.N_GLB(N_GLB), .N_SUM(N_SUM)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .async_i    (mode.async_clk),
  .neg_edge_i (mode.neg_edge),
  .t_mode_i   (mode.t_mode),
  .sum_code_i (code[N_SUM*2*(N_GLB+1)-1:0]),
  .pt_sum_i   (pt_sum),
  .clr_i      (pt_clr),
  .f_i        (f_val),
  .q_i        (q)
);

// File: tb/pterm_macrocell_tb_top.sv
module pterm_macrocell_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned N_GLB  = 8;
  localparam int unsigned N_SUM  = 8;
  localparam int unsigned ARR_W  = N_GLB + 1;
  localparam int unsigned M_W    = 6;
  localparam int unsigned CFG_W  = M_W + (N_SUM + 2) * 2 * ARR_W;
  localparam int T_CTL = 8, T_CLR = 9, J_FB = 8;
  localparam int B_INV = 0, B_T = 1, B_NEG = 2, B_ASY = 3, B_OREG = 4, B_FBP = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N_GLB-1:0] glb = '0;
  logic             pad_in = 1'b0;
  logic [CFG_W-1:0] cfg = '0;
  logic             pad_out, pad_oe, fb_out;
  logic             q_m = 1'b0;
  logic             done = 1'b0;
  int               n_run = 0;
  int               n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pterm_macrocell #(.N_GLB(N_GLB), .N_SUM(N_SUM)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .glb_i(glb), .pad_i(pad_in), .cfg_i(cfg),
    .pad_o(pad_out), .pad_oe_o(pad_oe), .fb_o(fb_out)
  );

  // ---------------- reference model ----------------
  function automatic logic [CFG_W-1:0] put(logic [CFG_W-1:0] c, int k, int j, logic [1:0] v);
    c[M_W + 2*(k*ARR_W + j) +: 2] = v;
    return c;
  endfunction

  function automatic logic term_val(int k, logic [ARR_W-1:0] a);
    logic used, all;
    used = 1'b0; all = 1'b1;
    for (int j = 0; j < ARR_W; j++) begin
      logic [1:0] c;
      c = cfg[M_W + 2*(k*ARR_W + j) +: 2];
      if (c == 2'b01) begin used = 1'b1; all &= a[j]; end
      else if (c == 2'b10) begin used = 1'b1; all &= ~a[j]; end
    end
    return used & all;
  endfunction

  function automatic logic [ARR_W-1:0] arr_now();
    return {(cfg[B_FBP] ? pad_in : q_m), glb};
  endfunction

  function automatic logic f_of(logic [ARR_W-1:0] a);
    logic s;
    s = 1'b0;
    for (int k = 0; k < N_SUM; k++) s |= term_val(k, a);
    return s ^ cfg[B_INV];
  endfunction

  function automatic logic [1:0] rnd_lit(int unsigned den);
    int unsigned r;
    r = $urandom % den;
    if (r == 0) return 2'b01;
    if (r == 1) return 2'b10;
    if (r == 2) return 2'b11;
    return 2'b00;
  endfunction

  // ---------------- check helpers ----------------
  task automatic chk(string req, logic act, logic exp, string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic check_outs(string req);
    logic [ARR_W-1:0] a;
    a = arr_now();
    chk(req, pad_out, cfg[B_OREG] ? q_m : f_of(a), "pad_o");
    chk(cfg[B_ASY] ? "R8" : "R7", pad_oe, cfg[B_ASY] ? 1'b1 : term_val(T_CTL, a), "pad_oe_o");
    chk("R10", fb_out, a[J_FB], "fb_o");
  endtask

  // config only changes with reset asserted (R11)
  task automatic apply_cfg(logic [CFG_W-1:0] c);
    @(posedge clk); #2;
    rst_n = 1'b0; glb = '0; pad_in = 1'b0;
    #1 cfg = c; q_m = 1'b0;
    @(posedge clk); #2;
    rst_n = 1'b1;
  endtask

  task automatic sync_step(logic [N_GLB-1:0] g, logic p, string req);
    logic [ARR_W-1:0] a;
    glb = g; pad_in = p;
    a = arr_now();
    if (term_val(T_CLR, a)) q_m = 1'b0;
    else if (cfg[B_T])      q_m = q_m ^ f_of(a);
    else                    q_m = f_of(a);
    @(posedge clk); #2;
    check_outs(req);
  endtask

  task automatic async_step(logic [N_GLB-2:0] d, logic p);
    logic [ARR_W-1:0] a;
    glb[N_GLB-2:0] = d; pad_in = p;
    #1;
    a = arr_now();
    q_m = cfg[B_T] ? (q_m ^ f_of(a)) : f_of(a);
    glb[N_GLB-1] = 1'b1; #1;
    glb[N_GLB-1] = 1'b0; #1;
    check_outs(cfg[B_T] ? "R5" : "R8");
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [CFG_W-1:0] c;
    void'($urandom(32'd20071));

    // reset state
    cfg = '0; cfg[B_OREG] = 1'b1;
    @(posedge clk); #2;
    chk("R11", pad_out, 1'b0, "pad_o in reset");
    chk("R7", pad_oe, 1'b0, "pad_oe_o in reset");

    // empty array, both polarities
    c = '0;
    apply_cfg(c);
    sync_step(8'hff, 1'b1, "R1");
    chk("R1", pad_out, 1'b0, "empty sum");
    c[B_INV] = 1'b1;
    apply_cfg(c);
    sync_step(8'h00, 1'b0, "R2");
    chk("R2", pad_out, 1'b1, "empty sum inverted");

    // reserved code acts as unused
    c = put('0, 0, 0, 2'b11);
    apply_cfg(c);
    sync_step(8'hff, 1'b0, "R1");
    chk("R1", pad_out, 1'b0, "reserved literal");

    // true and complemented literals, combinational output
    c = put(put('0, 0, 0, 2'b01), 0, 1, 2'b10);
    apply_cfg(c);
    sync_step(8'h01, 1'b0, "R3");
    chk("R3", pad_out, 1'b1, "g0 & ~g1");
    sync_step(8'h03, 1'b0, "R3");
    chk("R3", pad_out, 1'b0, "g0 & ~g1 with g1 set");

    // T mode toggles and holds
    c = put('0, 0, 0, 2'b01); c[B_T] = 1'b1; c[B_OREG] = 1'b1;
    apply_cfg(c);
    sync_step(8'h01, 1'b0, "R5"); chk("R5", pad_out, 1'b1, "toggle 1");
    sync_step(8'h01, 1'b0, "R5"); chk("R5", pad_out, 1'b0, "toggle 2");
    sync_step(8'h01, 1'b0, "R5"); chk("R5", pad_out, 1'b1, "toggle 3");
    sync_step(8'h00, 1'b0, "R5"); chk("R5", pad_out, 1'b1, "hold");

    // asynchronous clear with priority over the edge
    c = put(put('0, 0, 0, 2'b01), T_CLR, 1, 2'b01); c[B_OREG] = 1'b1;
    apply_cfg(c);
    sync_step(8'h01, 1'b0, "R4"); chk("R4", pad_out, 1'b1, "D load");
    glb = 8'h03; q_m = 1'b0; #1;
    chk("R9", pad_out, 1'b0, "clear without edge");
    @(posedge clk); #2;
    chk("R9", pad_out, 1'b0, "clear beats edge");
    sync_step(8'h01, 1'b0, "R4"); chk("R4", pad_out, 1'b1, "reload after clear");

    // rising edge ignores the falling edge
    c = put('0, 0, 0, 2'b01); c[B_OREG] = 1'b1;
    apply_cfg(c);
    glb = 8'h01; #5;
    chk("R6", pad_out, 1'b0, "rising mode after falling edge");
    @(posedge clk); #2; q_m = 1'b1;
    chk("R6", pad_out, 1'b1, "rising mode after rising edge");

    // falling edge capture
    c[B_NEG] = 1'b1;
    apply_cfg(c);
    glb = 8'h01; #2;
    chk("R6", pad_out, 1'b0, "falling mode before falling edge");
    #3;
    chk("R6", pad_out, 1'b1, "falling mode after falling edge");
    @(posedge clk); #2; q_m = 1'b1;

    // pin feedback
    c = put('0, 0, J_FB, 2'b01); c[B_FBP] = 1'b1;
    apply_cfg(c);
    sync_step(8'h00, 1'b1, "R10"); chk("R10", pad_out, 1'b1, "pin fed back");
    sync_step(8'h00, 1'b0, "R10"); chk("R10", pad_out, 1'b0, "pin low fed back");

    // async mode: enable forced high with control term low
    c = put('0, T_CTL, N_GLB-1, 2'b01); c[B_ASY] = 1'b1;
    apply_cfg(c);
    chk("R8", pad_oe, 1'b1, "async enable");

    // random synchronous configurations
    for (int n = 0; n < 40; n++) begin
      c = '0;
      c[M_W-1:0] = 6'($urandom) & ~(6'b1 << B_ASY);
      for (int k = 0; k < N_SUM; k++)
        for (int j = 0; j < ARR_W; j++) c = put(c, k, j, rnd_lit(8));
      for (int j = 0; j < N_GLB; j++) c = put(c, T_CTL, j, rnd_lit(8));
      for (int j = 0; j < N_GLB; j++) c = put(c, T_CLR, j, rnd_lit(16));
      apply_cfg(c);
      for (int s = 0; s < 25; s++)
        sync_step(8'($urandom), 1'($urandom), cfg[B_OREG] ? (cfg[B_T] ? "R5" : "R4") : "R2");
    end

    // random asynchronous configurations, local clock on glb[7]
    for (int n = 0; n < 12; n++) begin
      c = '0;
      c[M_W-1:0] = 6'($urandom) | (6'b1 << B_ASY);
      for (int k = 0; k < N_SUM; k++)
        for (int j = 0; j < ARR_W; j++)
          if (j != N_GLB-1) c = put(c, k, j, rnd_lit(8));
      c = put(c, T_CTL, N_GLB-1, 2'b01);
      apply_cfg(c);
      for (int s = 0; s < 12; s++) async_step(7'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule